// File: doc/BRIEF.md
# Fetch Output Stash Stage

This stage sits between a block-RAM instruction cache and the decoder. The cache reads its memory with an address taken straight from the registered fetch address, so each read gets a whole cycle and cannot be cancelled. When decode raises its stall, the fetch address has already moved on and one more cache word is on its way. That word would be lost unless something holds it. The stage keeps a registered output word (valid, address, instruction) for decode and a one-entry stash beside it. In the first cycle of a stall it copies the live cache word into the stash. In the first cycle after the stall it hands that word to decode in place of the live cache output.

Upstream behaves as follows. The fetch address stops advancing in every cycle in which the stall is high. The cache output in cycle k is the word read from the fetch address of cycle k-1. A flush redirects the fetch address and makes the next cache output invalid. Under these rules, the cache word that arrives while a stall is held, and the one that arrives in the first cycle after it, are re-read later. The stage can therefore ignore them, and decode still sees every valid word once and in order. A flush input discards everything held.

Top module: `fetch_stash_stage`

## Requirements
- R1: While reset is high, and in the first cycle after it, the decode valid output is 0.
- R2: When stall was low in the previous two cycles and flush was low in the previous cycle, the decode outputs carry the cache valid, address and instruction from the previous cycle.
- R3: In the first cycle of a stall (stall high, low the cycle before) with no flush, the cache word is loaded into the stash, including its valid bit.
- R4: Cache outputs in the later cycles of a stall, and in the first cycle after a stall, have no effect on what decode receives, and they do not overwrite the stash.
- R5: In the cycle after any cycle with stall high and flush low, the decode outputs hold their values unless flush is high.
- R6: In the cycle after the first stall-low cycle that ends a stall, the decode outputs carry the word held in the stash. Live cache output resumes one cycle later.
- R7: A high flush forces the decode valid output to 0 in the same cycle. It also clears the output word and the stash valid bit, so the decode valid output is 0 in the next cycle as well.
- R8: With the upstream rules above, decode takes every valid cache word exactly once and in address order. This holds across single, long, back-to-back and flushed stalls. Decode takes a word in any cycle where the decode valid output is high and stall is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Redirect: kills held words |
| stall_i | input | 1 | Decode is not taking the current output |
| ic_valid_i | input | 1 | Cache output word is valid |
| ic_addr_i | input | ADDR_W | Cache output word address |
| ic_insn_i | input | INSN_W | Cache output instruction |
| dec_valid_o | output | 1 | Word to decode is valid |
| dec_addr_o | output | ADDR_W | Address of word to decode |
| dec_insn_o | output | INSN_W | Instruction to decode |

## Verification
The hardest case to reach from the ports is a word that exists only in the stash while a flush or a second stall arrives around the release cycle. A flush in the first stall cycle, a flush in the release cycle, and a stall that starts one cycle after release each need exact phasing between stall, flush and the cache's one-cycle read delay. The bench drives a model of the upstream fetch address with that delay. Directed sequences place flushes and stalls on each of those cycles. A long random run then mixes stall lengths with occasional flushes. In every cycle whose cache output must be ignored, the bench drives random junk on the cache inputs.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  // Source of the next value of the decode-facing output register
  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_LIVE  = 2'd1,
    SEL_STASH = 2'd2,
    SEL_KILL  = 2'd3
  } fsb_sel_e;

  // Kill beats hold, hold beats resume, anything else takes the live word
  function automatic fsb_sel_e fsb_pick(input logic kill, input logic hold,
                                        input logic resume);
    fsb_sel_e s;
    if (kill)        s = SEL_KILL;
    else if (hold)   s = SEL_HOLD;
    else if (resume) s = SEL_STASH;
    else             s = SEL_LIVE;
    return s;
  endfunction

endpackage

// File: rtl/fsb_stall_edge.sv
module fsb_stall_edge (
  input  logic clk,
  input  logic rst,
  input  logic stall_i,
  output logic first_o,
  output logic resume_o
);
  logic stall_q;

  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= stall_i;
  end

  assign first_o  = stall_i & ~stall_q;
  assign resume_o = ~stall_i & stall_q;
endmodule

// File: rtl/fsb_stash.sv
module fsb_stash #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill_i,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [INSN_W-1:0] in_insn,
  output logic              st_valid,
  output logic [ADDR_W-1:0] st_addr,
  output logic [INSN_W-1:0] st_insn
);
  localparam int WORD_W = ADDR_W + INSN_W;

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst || kill_i || drop_i) st_valid <= 1'b0;
    else if (load_i)             st_valid <= in_valid;
  end

  // Payload carries no reset so it maps onto plain flops with enable
  always_ff @(posedge clk) begin
    if (load_i) word_q <= {in_addr, in_insn};
  end

  assign st_addr = word_q[WORD_W-1:INSN_W];
  assign st_insn = word_q[INSN_W-1:0];
endmodule

// File: rtl/fsb_out_stage.sv
module fsb_out_stage
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  fsb_sel_e          sel,
  input  logic              live_valid,
  input  logic [ADDR_W-1:0] live_addr,
  input  logic [INSN_W-1:0] live_insn,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [INSN_W-1:0] st_insn,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic [INSN_W-1:0] q_insn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else begin
      unique case (sel)
        SEL_KILL:  q_valid <= 1'b0;
        SEL_HOLD:  q_valid <= q_valid;
        SEL_STASH: q_valid <= st_valid;
        default:   q_valid <= live_valid;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    unique case (sel)
      SEL_STASH: begin
        q_addr <= st_addr;
        q_insn <= st_insn;
      end
      SEL_LIVE: begin
        q_addr <= live_addr;
        q_insn <= live_insn;
      end
      default: begin
        q_addr <= q_addr;
        q_insn <= q_insn;
      end
    endcase
  end
endmodule

// File: rtl/fetch_stash_stage.sv
module fetch_stash_stage
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              stall_i,
  input  logic              ic_valid_i,
  input  logic [ADDR_W-1:0] ic_addr_i,
  input  logic [INSN_W-1:0] ic_insn_i,
  output logic              dec_valid_o,
  output logic [ADDR_W-1:0] dec_addr_o,
  output logic [INSN_W-1:0] dec_insn_o
);
  logic              first_stall, resume;
  logic              st_valid;
  logic [ADDR_W-1:0] st_addr;
  logic [INSN_W-1:0] st_insn;
  logic              q_valid;
  logic [ADDR_W-1:0] q_addr;
  logic [INSN_W-1:0] q_insn;
  fsb_sel_e          sel;

  fsb_stall_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .stall_i  (stall_i),
    .first_o  (first_stall),
    .resume_o (resume)
  );

  fsb_stash #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_stash (
    .clk      (clk),
    .rst      (rst),
    .kill_i   (flush_i),
    .load_i   (first_stall),
    .drop_i   (resume),
    .in_valid (ic_valid_i),
    .in_addr  (ic_addr_i),
    .in_insn  (ic_insn_i),
    .st_valid (st_valid),
    .st_addr  (st_addr),
    .st_insn  (st_insn)
  );

  assign sel = fsb_pick(flush_i, stall_i, resume);

  fsb_out_stage #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .live_valid (ic_valid_i),
    .live_addr  (ic_addr_i),
    .live_insn  (ic_insn_i),
    .st_valid   (st_valid),
    .st_addr    (st_addr),
    .st_insn    (st_insn),
    .q_valid    (q_valid),
    .q_addr     (q_addr),
    .q_insn     (q_insn)
  );

  assign dec_valid_o = q_valid & ~flush_i;
  assign dec_addr_o  = q_addr;
  assign dec_insn_o  = q_insn;

  // R2: plain pass-through one cycle later
  a_r2_pass: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !resume && !flush_i) |=>
      (q_valid == $past(ic_valid_i)) &&
      (!q_valid || (q_addr == $past(ic_addr_i) && q_insn == $past(ic_insn_i))));

  // R3: first stall cycle captures the in-flight word
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    (first_stall && !flush_i) |=>
      (st_valid == $past(ic_valid_i)) &&
      (st_addr == $past(ic_addr_i)) && (st_insn == $past(ic_insn_i)));

  // R4: later stall cycles leave the stash untouched
  a_r4_keep: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !first_stall && !flush_i) |=>
      $stable(st_valid) && $stable(st_addr) && $stable(st_insn));

  // R5: output register holds while decode stalls
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !flush_i) |=>
      $stable(q_valid) && $stable(q_addr) && $stable(q_insn));

  // R6: release cycle hands over the stash contents
  a_r6_resume: assert property (@(posedge clk) disable iff (rst)
    (resume && !flush_i) |=>
      (q_valid == $past(st_valid)) &&
      (!q_valid || (q_addr == $past(st_addr) && q_insn == $past(st_insn))));

  // R7: flush empties both the output and the stash
  a_r7_flush: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!q_valid && !st_valid));
endmodule

// File: tb/fetch_stash_stage_bench.sv
module fetch_stash_stage_bench;
  localparam int AW = 32;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush_i = 1'b0;
  logic          stall_i = 1'b0;
  logic          ic_valid_i = 1'b0;
  logic [AW-1:0] ic_addr_i = '0;
  logic [IW-1:0] ic_insn_i = '0;
  logic          dec_valid_o;
  logic [AW-1:0] dec_addr_o;
  logic [IW-1:0] dec_insn_o;

  always #10 clk = ~clk;

  fetch_stash_stage #(.ADDR_W(AW), .INSN_W(IW)) u_fetch_stash_stage (
    .clk(clk), .rst(rst), .flush_i(flush_i), .stall_i(stall_i),
    .ic_valid_i(ic_valid_i), .ic_addr_i(ic_addr_i), .ic_insn_i(ic_insn_i),
    .dec_valid_o(dec_valid_o), .dec_addr_o(dec_addr_o), .dec_insn_o(dec_insn_o)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // Memory image seen by the upstream model
  function automatic logic word_ok(input logic [AW-1:0] a);
    logic [AW-1:0] h;
    h = (a >> 2) * 32'h9E37_79B1;
    return h[31:29] != 3'd0;
  endfunction
  function automatic logic [IW-1:0] word_of(input logic [AW-1:0] a);
    return (a * 32'h0101_0F1D) ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Upstream model and bench history
  logic [AW-1:0] fa = '0;
  logic          p_st = 0, p_fl = 1;
  logic [AW-1:0] p_tg = '0;
  logic          h1_st = 0, h1_fl = 1, h1_cv = 0, h2_st = 0;
  logic [AW-1:0] h1_ca = '0;
  logic [IW-1:0] h1_ci = '0;
  logic          sm_v = 0;
  logic [AW-1:0] sm_a = '0;
  logic [IW-1:0] sm_i = '0;
  logic          po_v = 0;
  logic [AW-1:0] po_a = '0;
  logic [IW-1:0] po_i = '0;
  logic [AW-1:0] exp_a = '0;

  task automatic cyc(input logic st, input logic fl, input logic [AW-1:0] tg);
    logic cv; logic [AW-1:0] ca; logic [IW-1:0] ci;
    @(posedge clk); #2;
    cv = !p_fl && word_ok(fa);
    ca = fa;
    ci = word_of(fa);
    fa = p_fl ? p_tg : (p_st ? fa : fa + 32'd4);
    if (p_st) begin  // R4: ignored cycle, drive junk
      cv = 1'($urandom);
      ca = $urandom;
      ci = $urandom;
    end
    ic_valid_i = cv; ic_addr_i = ca; ic_insn_i = ci;
    stall_i = st; flush_i = fl;
    @(negedge clk);
    if (fl) chk(dec_valid_o == 1'b0, "R7 same-cycle kill", 64'(dec_valid_o), 64'd0);
    if (h1_fl && !fl) chk(dec_valid_o == 1'b0, "R7 cleared after flush", 64'(dec_valid_o), 64'd0);
    if (!h1_st && !h2_st && !fl && !h1_fl) begin
      chk(dec_valid_o == h1_cv, "R2 valid pass", 64'(dec_valid_o), 64'(h1_cv));
      if (h1_cv) chk(dec_addr_o == h1_ca && dec_insn_o == h1_ci, "R2 word pass",
                     {dec_addr_o, dec_insn_o}, {h1_ca, h1_ci});
    end
    if (!h1_st && h2_st && !fl) begin
      chk(dec_valid_o == sm_v, "R6 stash valid (R3,R4)", 64'(dec_valid_o), 64'(sm_v));
      if (sm_v) chk(dec_addr_o == sm_a && dec_insn_o == sm_i, "R6 stash word (R3,R4)",
                    {dec_addr_o, dec_insn_o}, {sm_a, sm_i});
    end
    if (h1_st && !h1_fl && !fl)
      chk(dec_valid_o == po_v && (!po_v || (dec_addr_o == po_a && dec_insn_o == po_i)),
          "R5 hold", {31'd0, dec_valid_o, dec_addr_o}, {31'd0, po_v, po_a});
    if (dec_valid_o && !st) begin
      while (!word_ok(exp_a)) exp_a = exp_a + 32'd4;
      chk(dec_addr_o == exp_a && dec_insn_o == word_of(exp_a), "R8 stream order",
          {dec_addr_o, dec_insn_o}, {exp_a, word_of(exp_a)});
      exp_a = exp_a + 32'd4;
    end
    if (fl) exp_a = tg;
    // update stash model with this cycle
    if (fl) sm_v = 0;
    else if (st && !h1_st) begin sm_v = cv; sm_a = ca; sm_i = ci; end
    po_v = dec_valid_o; po_a = dec_addr_o; po_i = dec_insn_o;
    h2_st = h1_st; h1_st = st; h1_fl = fl; h1_cv = cv; h1_ca = ca; h1_ci = ci;
    p_st = st; p_fl = fl; p_tg = tg;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dec_valid_o == 1'b0, "R1 reset valid", 64'(dec_valid_o), 64'd0);
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk);
    chk(dec_valid_o == 1'b0, "R1 after reset", 64'(dec_valid_o), 64'd0);
    run(8);
    cyc(1, 0, '0); run(4);                                       // single stall
    cyc(1, 0, '0); cyc(1, 0, '0); cyc(1, 0, '0); run(4);         // long stall
    for (int i = 0; i < 6; i++) begin cyc(1, 0, '0); cyc(0, 0, '0); end // back-to-back
    run(3);
    cyc(1, 0, '0); cyc(1, 1, 32'h400); cyc(1, 0, '0); run(5);    // flush mid-stall
    cyc(1, 1, 32'h800); cyc(1, 0, '0); run(5);                   // flush on first stall
    cyc(1, 0, '0); cyc(0, 1, 32'hC00); run(5);                   // flush on release
    cyc(0, 1, 32'h1000); cyc(1, 0, '0); cyc(0, 0, '0); run(5);   // stall right after flush
    for (int i = 0; i < 4000; i++) begin
      logic st, fl;
      st = ($urandom % 100) < 40;
      fl = ($urandom % 100) < 3;
      cyc(st, fl, ($urandom % 32'h10000) & ~32'd3);
    end
    run(6);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule